// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and an incoming carry in a single combinational pass, producing the sum and the outgoing carry. The operand is split into equal groups of bits. Every bit derives a generate flag (both operand bits high) and a propagate flag (either operand bit high). A lookahead unit per group turns those flags into the group's internal carries, and it also condenses them into one group-wide propagate and generate pair.

A second lookahead unit of the same shape takes the group pairs and the incoming carry. It produces every group's carry-in and the final carry-out directly, so no carry travels serially from one group to the next. Each sum bit is the exclusive-or of the two operand bits and the carry into that bit. The block is placed wherever a datapath needs a wide add whose delay grows with the logarithm of the width rather than linearly with it. The default build is 16 bits wide, organised as four groups of four bits.

Top module: `claAdderTop`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH for any operand values.
- R2: `carryOut` equals bit WIDTH of the full-precision value `opA` + `opB` + `carryIn`.
- R3: With both operands zero and `carryIn` low, `sumOut` is zero and `carryOut` is low.
- R4: When every bit only propagates (`opA` = 0xAAAA, `opB` = 0x5555), the result is 0xFFFF with no carry-out if `carryIn` is low. It is 0x0000 with a carry-out if `carryIn` is high.
- R5: A carry generated in the lowest bit reaches every higher group: `opA` = 0x0001 with `opB` = 0xFFFF gives `sumOut` 0x0000 and `carryOut` high.
- R6: The carry into each group equals the carry leaving the group below it. For example, 0x000F + 0x0001 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.
- R7: With both operands at their maximum and `carryIn` high, `sumOut` is all ones and `carryOut` is high.
- R8: The outputs depend only on the present inputs; a new input vector is reflected in the same cycle, without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH (16) | First addend |
| opB | input | WIDTH (16) | Second addend |
| carryIn | input | 1 | Carry into the least significant bit |
| sumOut | output | WIDTH (16) | Sum, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds the adder with its defaults: WIDTH of 16 and a group width of 4, giving four groups and a four-input second level. This makes the group boundaries at bits 4, 8 and 12 directly reachable with small hand-picked operands. It also makes full-length propagate chains reachable, where a carry from bit 0 must cross all three boundaries through the second level. Random vectors, compared against a behavioural full-precision sum, cover mixed generate, propagate and kill patterns in every group.

// File: rtl/claPkg.sv
package claPkg;
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;
endpackage

// File: rtl/claBitCell.sv
module claBitCell
  import claPkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  input  logic    carryBit,
  output pgPair_t pgOut,
  output logic    sumBit
);
  always_comb begin
    pgOut.gen  = aBit & bBit;
    pgOut.prop = aBit | bBit;
    sumBit     = aBit ^ bBit ^ carryBit;
  end

  // R1
  always_comb begin
    if (!$isunknown({aBit, bBit}))
      gen_implies_prop_chk: assert (!pgOut.gen || pgOut.prop);
  end
endmodule

// File: rtl/claLookahead.sv
module claLookahead #(
  parameter int LA_W = 4
) (
  input  logic [LA_W-1:0] propIn,
  input  logic [LA_W-1:0] genIn,
  input  logic            cIn,
  output logic [LA_W:1]   carryVec,
  output logic            blockProp,
  output logic            blockGen
);
  // Each carry is a flat sum of products: no term depends on a lower carry.
  always_comb begin
    for (int i = 0; i < LA_W; i++) begin
      logic acc;
      logic chainAll;
      chainAll = cIn;
      for (int j = 0; j <= i; j++) chainAll = chainAll & propIn[j];
      acc = chainAll;
      for (int j = 0; j <= i; j++) begin
        logic term;
        term = genIn[j];
        for (int k = j + 1; k <= i; k++) term = term & propIn[k];
        acc = acc | term;
      end
      carryVec[i+1] = acc;
    end
  end

  always_comb begin
    blockProp = &propIn;
    blockGen  = 1'b0;
    for (int j = 0; j < LA_W; j++) begin
      logic term;
      term = genIn[j];
      for (int k = j + 1; k < LA_W; k++) term = term & propIn[k];
      blockGen = blockGen | term;
    end
  end

  // R2
  always_comb begin
    if (!$isunknown({propIn, genIn, cIn}))
      block_pair_chk: assert (carryVec[LA_W] == (blockGen | (blockProp & cIn)));
  end
endmodule

// File: rtl/claAdderTop.sv
module claAdderTop
  import claPkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NUM_GROUPS = WIDTH / GROUP_W;

  pgPair_t [WIDTH-1:0]      bitPg;
  logic    [WIDTH-1:0]      bitCarry;
  logic    [WIDTH-1:0]      bitProp;
  logic    [WIDTH-1:0]      bitGen;
  logic    [NUM_GROUPS-1:0] grpProp;
  logic    [NUM_GROUPS-1:0] grpGen;
  logic    [NUM_GROUPS:0]   grpCarry;
  logic    [NUM_GROUPS:1]   upperCarry;
  logic                     topProp;
  logic                     topGen;

  for (genvar bi = 0; bi < WIDTH; bi++) begin : g_bit
    claBitCell u_cell (
      .aBit    (opA[bi]),
      .bBit    (opB[bi]),
      .carryBit(bitCarry[bi]),
      .pgOut   (bitPg[bi]),
      .sumBit  (sumOut[bi])
    );
    assign bitProp[bi] = bitPg[bi].prop;
    assign bitGen[bi]  = bitPg[bi].gen;
  end

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
    logic [GROUP_W:1] innerCarry;
    claLookahead #(.LA_W(GROUP_W)) u_grpLa (
      .propIn   (bitProp[gi*GROUP_W +: GROUP_W]),
      .genIn    (bitGen[gi*GROUP_W +: GROUP_W]),
      .cIn      (grpCarry[gi]),
      .carryVec (innerCarry),
      .blockProp(grpProp[gi]),
      .blockGen (grpGen[gi])
    );
    assign bitCarry[gi*GROUP_W] = grpCarry[gi];
    for (genvar k = 1; k < GROUP_W; k++) begin : g_inner
      assign bitCarry[gi*GROUP_W + k] = innerCarry[k];
    end

    // R6
    always_comb begin
      if (!$isunknown({opA, opB, carryIn}))
        group_handoff_chk: assert (innerCarry[GROUP_W] == grpCarry[gi+1]);
    end
  end

  claLookahead #(.LA_W(NUM_GROUPS)) u_topLa (
    .propIn   (grpProp),
    .genIn    (grpGen),
    .cIn      (carryIn),
    .carryVec (upperCarry),
    .blockProp(topProp),
    .blockGen (topGen)
  );

  assign grpCarry[0]              = carryIn;
  assign grpCarry[NUM_GROUPS:1]   = upperCarry;
  assign carryOut                 = grpCarry[NUM_GROUPS];

  // R1
  always_comb begin
    if (!$isunknown({opA, opB, carryIn}))
      sum_value_chk: assert ({carryOut, sumOut} ==
        ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}));
  end

  // R2
  always_comb begin
    if (!$isunknown({opA, opB, carryIn}))
      carry_out_chk: assert (carryOut == (topGen | (topProp & carryIn)));
  end
endmodule

// File: tb/claAdderTop_tb.sv
module claAdderTop_tb_top;
  localparam int WIDTH   = 16;
  localparam int GROUP_W = 4;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic             carryIn = 1'b0;
  logic [WIDTH-1:0] sumOut;
  logic             carryOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  claAdderTop #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  // Drive on a rising edge, compare at the following falling edge.
  task automatic applyVec(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                          input logic c, input string req);
    logic [WIDTH:0] expVal;
    @(posedge clk);
    opA = a; opB = b; carryIn = c;
    expVal = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
    @(negedge clk);
    checks++;
    if (sumOut !== expVal[WIDTH-1:0]) begin
      failures++;
      $display("FAIL %s sum a=%h b=%h c=%0b actual=%h expected=%h",
               req, a, b, c, sumOut, expVal[WIDTH-1:0]);
    end
    checks++;
    if (carryOut !== expVal[WIDTH]) begin
      failures++;
      $display("FAIL %s carry a=%h b=%h c=%0b actual=%0b expected=%0b",
               req, a, b, c, carryOut, expVal[WIDTH]);
    end
  endtask

  initial begin
    // R3 reset-like starting state: zero inputs
    applyVec('0, '0, 1'b0, "R3");
    // R4 all-propagate chain
    applyVec(16'hAAAA, 16'h5555, 1'b0, "R4");
    applyVec(16'hAAAA, 16'h5555, 1'b1, "R4");
    // R5 generate at bit 0 crosses all groups
    applyVec(16'h0001, 16'hFFFF, 1'b0, "R5");
    applyVec(16'hFFFF, 16'h0000, 1'b1, "R5");
    // R6 each group boundary
    applyVec(16'h000F, 16'h0001, 1'b0, "R6");
    applyVec(16'h00FF, 16'h0001, 1'b0, "R6");
    applyVec(16'h0FFF, 16'h0001, 1'b0, "R6");
    applyVec(16'h0007, 16'h0008, 1'b1, "R6");
    applyVec(16'hF000, 16'h1000, 1'b0, "R6");
    // R7 both maximum
    applyVec(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    applyVec(16'hFFFF, 16'hFFFF, 1'b0, "R2");
    applyVec(16'h8000, 16'h8000, 1'b0, "R2");
    // R8 back-to-back vectors settle within the same cycle
    applyVec(16'h1234, 16'h4321, 1'b0, "R8");
    applyVec(16'hEDCB, 16'h1234, 1'b1, "R8");
    // R1 random operands
    for (int n = 0; n < 400; n++) begin
      applyVec(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R1");
    end
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule